// File: doc/BRIEF.md
# Supervisor Software Interrupt Set Pulser

This block is a memory-mapped bank of set-only interrupt registers, one 32-bit word per hart, used to send supervisor-level inter-processor interrupts. Software writes a 1 to bit 0 of a hart's word. The block then emits a single-cycle pulse on that hart's output line. The hart owns its pending flag and latches the pulse into it. The block keeps no readable state, so every read returns zero.

Requests arrive on a valid/ready channel carrying a write enable, a byte address and 32 bits of write data. The block never applies back-pressure: ready stays high, and every request is taken in the cycle its valid is high. Reads answer with a response valid one cycle later, and the response data is always zero. The response channel has no ready, because a consumer of all-zero data never needs to stall. The pulse is registered, so delivery lags the write by one cycle. This lag is allowed because a hart only needs each event to arrive eventually.

Top module: `swi_set_pulser`

## Requirements
- R1: The word for hart n sits at byte offset 4×n. The hart index is taken from address bits 13:2, and address bits 1:0 are ignored.
- R2: An accepted write with write-data bit 0 equal to 1 to an index n below NUM_HARTS drives hart_pulse[n] high for exactly one cycle, in the cycle after the write is accepted.
- R3: A write with bit 0 equal to 0 produces no pulse. Bits 31:1 of the write data never affect the result.
- R4: Writes of 1 in consecutive cycles produce one pulse each, in consecutive cycles, and none is lost. This holds whether they go to the same hart or to different harts.
- R5: At most one bit of hart_pulse is high in any cycle. No pulse appears unless a qualifying write was accepted in the previous cycle.
- R6: Writes to an index at or above NUM_HARTS, or to the reserved word at offset 0x3FFC (index 4095), produce no pulse.
- R7: A read gives rsp_valid high in the next cycle with rsp_rdata equal to zero. This holds for any address, including after earlier writes of 1.
- R8: While rst is high, and in the first cycle after it falls, hart_pulse and rsp_valid are zero. Requests presented during reset are dropped.
- R9: req_ready is high in every cycle, so the block never stalls a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte address inside the bank |
| req_wdata | input | 32 | Write data; only bit 0 matters |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read response data (always zero) |
| hart_pulse | output | NUM_HARTS | One-cycle interrupt event per hart |

## Verification
Both results of this block are due exactly one clock edge after the request edge: the pulse for a write of 1, and the zero response for a read. The bench changes inputs on the falling edge. It then checks hart_pulse and rsp_valid on the next falling edge, half a cycle after the register has updated, and verifies that the line is low again one cycle later. A hart-side latch model counts pulses per hart, so a run of back-to-back writes must leave exactly one count per write.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 14;
  localparam int IDX_W  = ADDR_W - 2;
  localparam logic [IDX_W-1:0] RESERVED_IDX = '1;
  typedef logic [BUS_W-1:0] word_t;
endpackage

// File: rtl/swi_decode.sv
module swi_decode
  import swi_pkg::*;
#(
  parameter int NUM_HARTS = 8
) (
  input  logic                 rst,
  input  logic                 valid,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  word_t                wdata,
  output logic [NUM_HARTS-1:0] fire_vec,
  output logic                 rd_req
);
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             set_req;
  logic             unused_bits;

  assign idx         = addr[ADDR_W-1:2];
  assign unused_bits = ^{addr[1:0], wdata[BUS_W-1:1]};
  assign in_range    = (int'(idx) < NUM_HARTS) && (idx != RESERVED_IDX);
  assign set_req     = valid && we && wdata[0] && !rst && in_range;
  assign rd_req      = valid && !we && !rst;

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_sel
    assign fire_vec[i] = set_req && (int'(idx) == i);
  end
endmodule

// File: rtl/swi_pulse_bank.sv
module swi_pulse_bank #(
  parameter int NUM_HARTS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_HARTS-1:0] fire_vec,
  output logic [NUM_HARTS-1:0] pulse
);
  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    always_ff @(posedge clk) begin
      if (rst) pulse[i] <= 1'b0;
      else     pulse[i] <= fire_vec[i];
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse));
endmodule

// File: rtl/swi_read_zero.sv
module swi_read_zero
  import swi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_req,
  output logic  rsp_valid,
  output word_t rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= rd_req;
  end
  assign rsp_rdata = '0;
endmodule

// File: rtl/swi_set_pulser.sv
module swi_set_pulser
  import swi_pkg::*;
#(
  parameter int NUM_HARTS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_we,
  input  logic [13:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] hart_pulse
);
  logic [NUM_HARTS-1:0] fire_vec;
  logic                 rd_req;

  assign req_ready = 1'b1;

  swi_decode #(.NUM_HARTS(NUM_HARTS)) u_dec (
    .rst(rst), .valid(req_valid), .we(req_we), .addr(req_addr),
    .wdata(req_wdata), .fire_vec(fire_vec), .rd_req(rd_req)
  );

  swi_pulse_bank #(.NUM_HARTS(NUM_HARTS)) u_bank (
    .clk(clk), .rst(rst), .fire_vec(fire_vec), .pulse(hart_pulse)
  );

  swi_read_zero u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_chk
    assert_pulse_after_set_R2: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_we && req_wdata[0] && (int'(req_addr[13:2]) == i))
      |=> hart_pulse[i]);
    assert_pulse_has_cause_R1: assert property (@(posedge clk) disable iff (rst)
      hart_pulse[i] |-> ($past(req_valid) && $past(req_we) &&
                         $past(req_wdata[0]) && (int'($past(req_addr[13:2])) == i)));
  end

  assert_zero_write_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && !req_wdata[0]) |=> (hart_pulse == '0));
  assert_out_of_range_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && (int'(req_addr[13:2]) >= NUM_HARTS)) |=> (hart_pulse == '0));
  assert_read_response_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we) |=> (rsp_valid && rsp_rdata == '0));
  assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (hart_pulse == '0 && !rsp_valid));
endmodule

// File: tb/swi_set_pulser_test.sv
module swi_set_pulser_test;
  localparam int NH = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [13:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NH-1:0] hart_pulse;
  int errors = 0, checks = 0;
  int pend_cnt [NH];
  bit done = 1'b0;

  always #4 clk = ~clk;

  swi_set_pulser #(.NUM_HARTS(NH)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hart_pulse(hart_pulse)
  );

  // hart-side latch model: counts events per hart, sampled off-edge
  always @(negedge clk) begin
    for (int i = 0; i < NH; i++) if (hart_pulse[i]) pend_cnt[i]++;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
  endtask

  // drive on a negedge; results checked on the next negedge
  task automatic wr(int idx, bit b0, logic [1:0] lo, logic [31:0] hi, string req);
    logic [NH-1:0] exp;
    exp = (b0 && idx < NH) ? (NH'(1) << idx) : '0;
    req_valid = 1; req_we = 1; req_addr = {idx[11:0], lo};
    req_wdata = {hi[31:1], b0};
    @(negedge clk);
    idle();
    check(req, 64'(hart_pulse), 64'(exp));
    check(req, 64'(rsp_valid), 64'd0);
    @(negedge clk);
    check(req, 64'(hart_pulse), 64'd0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NH; i++) pend_cnt[i] = 0;
    // R8: request during reset dropped, outputs zero during and after
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 14'd4; req_wdata = 32'd1;
    @(negedge clk);
    check("R8", 64'(hart_pulse), 64'd0);
    rst = 0;
    idle();
    @(negedge clk);
    check("R8", 64'(hart_pulse), 64'd0);
    check("R8", 64'(rsp_valid), 64'd0);
    check("R9", 64'(req_ready), 64'd1);
    for (int i = 0; i < NH; i++) pend_cnt[i] = 0;

    // R1 R2 R3 R6: sweep indices, bit0 values, low address bits, high data bits
    for (int idx = 0; idx < 16; idx++)
      for (int b = 0; b < 2; b++)
        wr(idx, b[0], 2'(idx), (b != 0) ? 32'hFFFF_FFFE : 32'hA5A5_A5A4,
           (idx >= NH) ? "R6" : (b != 0 ? "R2" : "R3"));
    wr(4095, 1'b1, 2'b00, 32'h0, "R6");
    wr(4095, 1'b0, 2'b11, 32'hFFFF_FFFE, "R6");
    for (int i = 0; i < NH; i++) check("R1", 64'(pend_cnt[i]), 64'd1);

    // R4: back-to-back writes to the same hart and to different harts
    for (int i = 0; i < NH; i++) pend_cnt[i] = 0;
    begin
      int seq[6] = '{3, 3, 3, 5, 0, 7};
      req_valid = 1; req_we = 1; req_wdata = 32'd1;
      req_addr = {12'(seq[0]), 2'b00};
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        check("R9", 64'(req_ready), 64'd1);
        check("R4", 64'(hart_pulse), 64'(NH'(1) << seq[k-1]));
        if (k < 6) req_addr = {12'(seq[k]), 2'b00};
        else idle();
      end
      @(negedge clk);
      check("R4", 64'(hart_pulse), 64'd0);
      check("R4", 64'(pend_cnt[3]), 64'd3);
      check("R4", 64'(pend_cnt[5]), 64'd1);
      check("R4", 64'(pend_cnt[4]), 64'd0);
    end

    // R7: reads return zero one cycle later, even after writes of 1
    for (int a = 0; a < 20; a++) begin
      req_valid = 1; req_we = 0; req_addr = 14'(a * 4 + (a % 4));
      if (a == 19) req_addr = 14'h3FFC;
      @(negedge clk);
      idle();
      check("R7", 64'(rsp_valid), 64'd1);
      check("R7", 64'(rsp_rdata), 64'd0);
      check("R5", 64'(hart_pulse), 64'd0);
      @(negedge clk);
      check("R7", 64'(rsp_valid), 64'd0);
    end

    // R5: idle valid-low cycles with write fields set produce nothing
    req_valid = 0; req_we = 1; req_addr = 14'd8; req_wdata = 32'd1;
    @(negedge clk);
    check("R5", 64'(hart_pulse), 64'd0);
    idle();

    // R8: reset mid-run clears a pending pulse
    req_valid = 1; req_we = 1; req_addr = 14'd8; req_wdata = 32'd1; rst = 1;
    @(negedge clk);
    idle();
    check("R8", 64'(hart_pulse), 64'd0);
    rst = 0;
    @(negedge clk);
    check("R8", 64'(hart_pulse), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule